// File: doc/BRIEF.md
# T1 Transmit Multiframe Timing Generator

This block runs on the transmit bit clock of a T1 stream. It tracks the bit position inside a 193-bit frame and the frame number inside a multiframe. From these it produces the registered timing strobes that neighbouring logic uses to place payload, signaling and framing bits.

The strobes are:
- a channel clock that marks each 8-bit channel;
- a multiframe marker;
- a signaling select;
- a signaling-frame flag;
- a line clock.

Three framing arrangements are supported: a 12-frame superframe, a 24-frame extended superframe, and a data-multiplex arrangement. The data-multiplex arrangement keeps 12-frame timing but uses a one-bit line-clock pulse per frame.

A rising edge on the sync input realigns the counters to the first bit of frame 1. This lets the multiframe be locked to an outside reference. Payload handling, signaling insertion and line coding live elsewhere.

Top module: `t1_tx_mf_timer`

## Requirements
- R1: While reset is held, and at the first sample after reset is released, the outputs show position frame 1, bit 0. That is: channel clock 0, multiframe marker 1, signaling select 1, signaling-frame flag 0, line clock 1. This holds in every mode.
- R2: A frame is 193 bit clocks. Bit 0 is the framing bit, and during it the channel clock is low. Bits 1–192 form 24 channels of 8 bits. Within each channel the channel clock is high for the first 4 bits and low for the last 4, so it rises 24 times per frame.
- R3: With modeSel 00 (12-frame) or 10 (data-multiplex), the multiframe is 12 frames. The multiframe marker is high in frames 1–6 and low in frames 7–12, and frame 12 is followed by frame 1.
- R4: With modeSel 01 (24-frame), the multiframe is 24 frames. The multiframe marker is high in frames 1–12 and low in frames 13–24, and frame 24 is followed by frame 1.
- R5: The signaling select toggles at twice the marker rate. It is high in frames 1–3 and 7–9 of a 12-frame multiframe, and in frames 1–6 and 13–18 of a 24-frame multiframe.
- R6: The signaling-frame flag is high only in frames whose number is a multiple of 6.
- R7: In 12-frame and 24-frame modes the line clock is high for the whole of every odd-numbered frame and low for every even-numbered one.
- R8: In data-multiplex mode (modeSel 10) the line clock is high only during bit 0 of each frame.
- R9: At the first clock edge that samples mfSync high after it was low, the position becomes frame 1, bit 0, wherever the counters were. Holding mfSync high does not realign again, and counting resumes from there.
- R10: modeSel 11 behaves exactly as the 12-frame mode (00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 2 | Framing mode: 00 12-frame, 01 24-frame, 10 data-multiplex, 11 as 00 |
| mfSync | input | 1 | Multiframe realign; its rising edge loads frame 1, bit 0 |
| chanClk | output | 1 | Channel boundary clock |
| mfMark | output | 1 | Multiframe marker, high in the first half of the multiframe |
| sigSel | output | 1 | Signaling select at twice the marker rate |
| sigFrame | output | 1 | High during signaling frames |
| lineClk | output | 1 | Line/link clock: odd frames, or the framing bit in data-multiplex |

## Verification
A realign edge can arrive in the same cycle as a natural wrap. The wrap may be at the end of a frame or at the end of the last frame of the multiframe.

The bench raises mfSync on the last bit of frame 24 in 24-frame mode, where both paths lead to frame 1. It checks that the next sample shows frame 1, bit 0 and the one after shows bit 1, with no extra advance.

It also raises mfSync on the last bit of frame 6 in 12-frame mode. There the natural successor (frame 7, marker low) differs from the realign target, so the sample tells which path won.

// File: rtl/t1tm_pkg.sv
package t1tm_pkg;

  // Frame structure
  localparam int NUM_CHAN    = 24;
  localparam int CHAN_BITS   = 8;
  localparam int FRAME_BITS  = 1 + NUM_CHAN * CHAN_BITS;
  localparam int BIT_W       = $clog2(FRAME_BITS);

  // Multiframe lengths
  localparam int SF_LEN      = 12;
  localparam int ESF_LEN     = 24;
  localparam int FRAME_W     = $clog2(ESF_LEN + 1);
  localparam int SIG_SPACING = SF_LEN / 2;

  typedef enum logic [1:0] {
    MODE_SF  = 2'b00,
    MODE_ESF = 2'b01,
    MODE_DM  = 2'b10,
    MODE_ALT = 2'b11
  } frameMode_e;

  // Look-ahead position handed from control to datapath
  typedef struct packed {
    logic [BIT_W-1:0]   bitPos;
    logic [FRAME_W-1:0] frameNum;
  } posStrobe_t;

  typedef struct packed {
    logic chanClk;
    logic mfMark;
    logic sigSel;
    logic sigFrame;
    logic lineClk;
  } outStrobe_t;

endpackage

// File: rtl/t1tm_ctrl.sv
module t1tm_ctrl
  import t1tm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  frameMode_e mode,
  input  logic       mfSync,
  output posStrobe_t nextPos,
  output logic       resync
);

  logic [BIT_W-1:0]   bitCnt;
  logic [FRAME_W-1:0] frameCnt;
  logic [FRAME_W-1:0] lastFrame;
  logic               syncPrev;
  logic               frameEnd;

  // Last frame number of the multiframe for the selected mode
  always_comb begin
    if (mode == MODE_ESF) lastFrame = FRAME_W'(ESF_LEN);
    else                  lastFrame = FRAME_W'(SF_LEN);
  end

  // Realign happens on a rising edge of the sync input only
  assign resync   = mfSync & ~syncPrev;
  assign frameEnd = (bitCnt == BIT_W'(FRAME_BITS - 1));

  always_comb begin
    nextPos.bitPos   = frameEnd ? '0 : bitCnt + 1'b1;
    nextPos.frameNum = frameCnt;
    if (frameEnd) begin
      if (frameCnt >= lastFrame) nextPos.frameNum = FRAME_W'(1);
      else                       nextPos.frameNum = frameCnt + 1'b1;
    end
    if (resync) begin
      nextPos.bitPos   = '0;
      nextPos.frameNum = FRAME_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      frameCnt <= FRAME_W'(1);
      syncPrev <= 1'b0;
    end else begin
      bitCnt   <= nextPos.bitPos;
      frameCnt <= nextPos.frameNum;
      syncPrev <= mfSync;
    end
  end

endmodule

// File: rtl/t1tm_dpath.sv
module t1tm_dpath
  import t1tm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  frameMode_e mode,
  input  posStrobe_t nextPos,
  output logic       chanClk,
  output logic       mfMark,
  output logic       sigSel,
  output logic       sigFrame,
  output logic       lineClk
);

  localparam int  HALF_CHAN = CHAN_BITS / 2;
  localparam bit  CHAN_POW2 = (CHAN_BITS & (CHAN_BITS - 1)) == 0;

  logic [BIT_W-1:0] chanOffs;
  logic             chanHigh;
  outStrobe_t       q;

  assign chanOffs = nextPos.bitPos - 1'b1;

  // Channel clock decode: masked when the channel width is a power of two
  generate
    if (CHAN_POW2) begin : g_maskDecode
      always_comb
        chanHigh = (nextPos.bitPos != '0) &&
                   ((chanOffs & BIT_W'(CHAN_BITS - 1)) < BIT_W'(HALF_CHAN));
    end else begin : g_modDecode
      always_comb
        chanHigh = (nextPos.bitPos != '0) &&
                   ((int'(chanOffs) % CHAN_BITS) < HALF_CHAN);
    end
  endgenerate

  function automatic outStrobe_t decodePos(frameMode_e m,
                                           logic [BIT_W-1:0] b,
                                           logic [FRAME_W-1:0] f,
                                           logic cc);
    outStrobe_t o;
    int len;
    int idx;
    len        = (m == MODE_ESF) ? ESF_LEN : SF_LEN;
    idx        = int'(f) - 1;
    o.chanClk  = cc;
    o.mfMark   = (idx < len / 2);
    o.sigSel   = ((idx % (len / 2)) < (len / 4));
    o.sigFrame = ((int'(f) % SIG_SPACING) == 0);
    o.lineClk  = (m == MODE_DM) ? (b == '0) : f[0];
    return o;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) q <= decodePos(mode, '0, FRAME_W'(1), 1'b0);
    else       q <= decodePos(mode, nextPos.bitPos, nextPos.frameNum, chanHigh);
  end

  assign chanClk  = q.chanClk;
  assign mfMark   = q.mfMark;
  assign sigSel   = q.sigSel;
  assign sigFrame = q.sigFrame;
  assign lineClk  = q.lineClk;

endmodule

// File: rtl/t1_tx_mf_timer.sv
module t1_tx_mf_timer
  import t1tm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       mfSync,
  output logic       chanClk,
  output logic       mfMark,
  output logic       sigSel,
  output logic       sigFrame,
  output logic       lineClk
);

  frameMode_e mode;
  posStrobe_t nextPos;
  logic       resyncPulse;

  assign mode = frameMode_e'(modeSel);

  t1tm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .mode    (mode),
    .mfSync  (mfSync),
    .nextPos (nextPos),
    .resync  (resyncPulse)
  );

  t1tm_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .nextPos  (nextPos),
    .chanClk  (chanClk),
    .mfMark   (mfMark),
    .sigSel   (sigSel),
    .sigFrame (sigFrame),
    .lineClk  (lineClk)
  );

endmodule

// File: rtl/t1tm_chk.sv
module t1tm_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       resync,
  input logic       chanClk,
  input logic       mfMark,
  input logic       sigSel,
  input logic       sigFrame,
  input logic       lineClk
);

  // R9
  realign_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> (mfMark && sigSel && !sigFrame && lineClk && !chanClk));

  // R4 (and R3): a new multiframe follows a signaling frame or a realign
  mf_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mfMark) |-> ($past(sigFrame) || $past(resync)));

  // R8
  dm_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 2'b10 && lineClk) |-> !chanClk);

  // R7
  line_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineClk != $past(lineClk) && $past(modeSel) != 2'b10) |-> !chanClk);

  // R5
  half_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mfMark) |-> sigSel);

endmodule

bind t1_tx_mf_timer t1tm_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .modeSel  (modeSel),
  .resync   (resyncPulse),
  .chanClk  (chanClk),
  .mfMark   (mfMark),
  .sigSel   (sigSel),
  .sigFrame (sigFrame),
  .lineClk  (lineClk)
);

// File: tb/t1_tx_mf_timer_test.sv
`timescale 1ns/1ps
module t1_tx_mf_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       mfSync = 1'b0;
  logic       chanClk, mfMark, sigSel, sigFrame, lineClk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  t1_tx_mf_timer uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .mfSync(mfSync),
    .chanClk(chanClk), .mfMark(mfMark), .sigSel(sigSel),
    .sigFrame(sigFrame), .lineClk(lineClk)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [4:0] frame;
    logic [7:0] bitp;
    logic [4:0] exp;   // {chanClk, mfMark, sigSel, sigFrame, lineClk}
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    // 12-frame: R2 R3 R5 R6 R7
    '{2'd0, 5'd1,  8'd0,   5'b01101},
    '{2'd0, 5'd1,  8'd1,   5'b11101},
    '{2'd0, 5'd1,  8'd5,   5'b01101},
    '{2'd0, 5'd1,  8'd9,   5'b11101},
    '{2'd0, 5'd1,  8'd192, 5'b01101},
    '{2'd0, 5'd2,  8'd4,   5'b11100},
    '{2'd0, 5'd3,  8'd0,   5'b01101},
    '{2'd0, 5'd4,  8'd0,   5'b01000},
    '{2'd0, 5'd6,  8'd0,   5'b01010},
    '{2'd0, 5'd7,  8'd0,   5'b00101},
    '{2'd0, 5'd12, 8'd0,   5'b00010},
    '{2'd0, 5'd13, 8'd0,   5'b01101},
    // 24-frame: R4 R5 R6 R7
    '{2'd1, 5'd6,  8'd0,   5'b01110},
    '{2'd1, 5'd12, 8'd0,   5'b01010},
    '{2'd1, 5'd13, 8'd0,   5'b00101},
    '{2'd1, 5'd18, 8'd0,   5'b00110},
    '{2'd1, 5'd19, 8'd0,   5'b00001},
    '{2'd1, 5'd24, 8'd0,   5'b00010},
    '{2'd1, 5'd25, 8'd0,   5'b01101},
    // data-multiplex: R3 R5 R6 R8
    '{2'd2, 5'd1,  8'd0,   5'b01101},
    '{2'd2, 5'd1,  8'd1,   5'b11100},
    '{2'd2, 5'd2,  8'd0,   5'b01101},
    '{2'd2, 5'd2,  8'd100, 5'b11100},
    '{2'd2, 5'd6,  8'd0,   5'b01011},
    '{2'd2, 5'd7,  8'd50,  5'b10100},
    '{2'd2, 5'd13, 8'd0,   5'b01101},
    // alternate code: R10
    '{2'd3, 5'd7,  8'd0,   5'b00101},
    '{2'd3, 5'd12, 8'd0,   5'b00010},
    '{2'd3, 5'd13, 8'd0,   5'b01101}
  };

  function automatic string reqText(logic [1:0] m);
    case (m)
      2'd0:    return "R2 R3 R5 R6 R7";
      2'd1:    return "R2 R4 R5 R6 R7";
      2'd2:    return "R2 R3 R5 R6 R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic [4:0] exp, input string tag);
    logic [4:0] act;
    act = {chanClk, mfMark, sigSel, sigFrame, lineClk};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic checkCount(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    rstN = 1'b0;
    modeSel = m;
    mfSync = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int rises, highs, badPos;
    logic prevCc;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      doReset(VECS[i].mode);
      repeat ((int'(VECS[i].frame) - 1) * 193 + int'(VECS[i].bitp)) @(negedge clk);
      check(VECS[i].exp, reqText(VECS[i].mode));
    end

    // R1: outputs while reset is held after running, each mode
    for (int m = 0; m < 3; m++) begin
      doReset(2'(m));
      repeat (1000) @(negedge clk);
      rstN = 1'b0;
      repeat (2) @(negedge clk);
      check(5'b01101, "R1 held");
      rstN = 1'b1;
      check(5'b01101, "R1 release");
    end

    // R2: channel clock edges and high time across one frame
    doReset(2'd0);
    rises = 0; highs = 0; prevCc = chanClk;
    for (int k = 0; k < 193; k++) begin
      if (k > 0) @(negedge clk);
      if (chanClk && !prevCc) rises++;
      if (chanClk) highs++;
      prevCc = chanClk;
    end
    checkCount(rises, 24, "R2 rises");
    checkCount(highs, 96, "R2 highs");

    // R8: line clock pulses in data-multiplex over two frames
    doReset(2'd2);
    highs = 0; badPos = 0;
    for (int k = 0; k < 386; k++) begin
      if (k > 0) @(negedge clk);
      if (lineClk) begin
        highs++;
        if ((k % 193) != 0) badPos++;
      end
    end
    checkCount(highs, 2, "R8 pulses");
    checkCount(badPos, 0, "R8 position");

    // R9: realign mid-multiframe, hold, release, realign again
    doReset(2'd0);
    repeat (7 * 193 + 77) @(negedge clk);
    mfSync = 1'b1;
    @(negedge clk);
    check(5'b01101, "R9 realign");
    repeat (200) @(negedge clk);
    check(5'b01100, "R9 held high");
    mfSync = 1'b0;
    repeat (5) @(negedge clk);
    check(5'b11100, "R9 after release");
    mfSync = 1'b1;
    @(negedge clk);
    check(5'b01101, "R9 second edge");
    mfSync = 1'b0;

    // R9 with natural multiframe wrap in the same cycle (24-frame)
    doReset(2'd1);
    repeat (23 * 193 + 192) @(negedge clk);
    mfSync = 1'b1;
    @(negedge clk);
    check(5'b01101, "R9 R4 wrap coincide");
    @(negedge clk);
    check(5'b11101, "R9 R4 wrap next bit");
    mfSync = 1'b0;

    // R9 with natural frame wrap where the successor differs (12-frame)
    doReset(2'd0);
    repeat (5 * 193 + 192) @(negedge clk);
    check(5'b01010, "R6 frame 6 end");
    mfSync = 1'b1;
    @(negedge clk);
    check(5'b01101, "R9 R3 frame wrap");
    mfSync = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule